// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the device side of a serial NOR flash that answers one command: the single-line fast read. It watches the chip-select, serial clock and serial data-in pins. The pins are sampled through synchronizers into a faster system clock. After a valid opcode and a 24-bit start address, it waits a programmable number of idle clocks. It then streams bytes from a small internal read-only array on the serial data-out pin. The read address advances by one per byte and wraps at the top of the array, so a single command can read the whole array any number of times.

The output is presented as a data bit plus an output-enable for a pad driver. The enable is low whenever the block is not driving data. A busy input stands for an erase or program still in progress; when it is set at the moment the opcode completes, the command is dropped and the pin is never driven. Raising chip-select ends any transaction at any point and returns the block to waiting for an opcode.

Top module: `fr_responder`

## Requirements
- R1: A transaction whose first 8 bits, taken MSB first on rising serial-clock edges, equal 0x0B starts a read. Any other opcode leaves `so_oe` low until chip-select is deasserted.
- R2: The 24 bits after the opcode are the start address, MSB first. Only the low ADDR_BITS bits (8 by default) select a byte. The upper address bits have no effect on the data returned.
- R3: After the last address bit, the block lets `dummy_cfg` rising edges pass before data. `dummy_cfg` is sampled on the last address bit, and a value of 0 means no gap.
- R4: Data leaves MSB first. `so` changes only in response to a falling serial-clock edge. The first data bit appears after the first falling edge that follows the last address or dummy rising edge.
- R5: The read address increments by one after each byte and wraps from the array's top byte (0xFF by default) to 0. The burst continues for as long as the clock runs.
- R6: `so_oe` is low during the opcode, address and dummy phases. It returns low no more than 4 system clocks after `cs_n` rises.
- R7: If `busy` is high when the 8th opcode bit is sampled, the command is ignored and `so_oe` stays low. `busy` at any other time has no effect.
- R8: Raising `cs_n` at any point, including in the middle of the address, returns the block to opcode decode. The next transaction is then served normally.
- R9: The block works with the serial clock idling low (mode 0) and idling high (mode 3).
- R10: The byte stored at array index a is ((a*37 + 11) mod 256) XOR (a >> 2), where a is the index taken to 8 bits.
- R11: After reset, `so_oe` and `so` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select pin, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data-in pin |
| busy | input | 1 | Write-in-progress flag; blocks a read when the opcode completes |
| dummy_cfg | input | DUMMY_W | Number of dummy clocks between address and data |
| so | output | 1 | Serial data-out bit |
| so_oe | output | 1 | Drive enable for the data-out pad (0 = high impedance) |

## Verification
The hardest situation to reach is `busy` asserted only in the narrow window where the last opcode bit is sampled. The same applies to `busy` asserted only just after that window. The stimulus raises `busy` for exactly the serial clock that carries opcode bit 8, and in a separate run only from the first address bit onward. The two runs must then give opposite results. The dummy-gap sweep also runs in both clock modes, so that the first data bit lands on each possible falling edge. One burst runs past the full array to show the wrap from the top byte back to zero.

// File: rtl/fr_pkg.sv
// Shared types and constants for the fast-read responder.
// Assumes an 8-bit opcode and a 24-bit address on the serial bus.
package fr_pkg;

    typedef enum logic [2:0] {
        PH_OPC    = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_DATA   = 3'd3,
        PH_IGNORE = 3'd4
    } fr_phase_e;

    localparam logic [7:0] FR_OPCODE   = 8'h0B;
    localparam int         FR_OPC_BITS = 8;
    localparam int         FR_BUS_ABITS = 24;

    // Content of the read-only array at a given index (index taken to 8 bits).
    function automatic logic [7:0] fr_rom_byte(input int unsigned idx);
        logic [7:0] lo;
        lo = idx[7:0];
        return 8'(lo * 8'd37 + 8'd11) ^ (lo >> 2);
    endfunction

endpackage

// File: rtl/fr_pin_sync.sv
// Brings the chip-select, clock and data pins into the system clock domain.
// Detects serial-clock edges. All three pins use the same number of stages,
// so their relative timing is kept. Assumes the system clock is several times
// faster than the serial clock.
module fr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);

    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] si_q;
    logic              sck_d;

    // Shift the pins through the synchronizer chains and keep the last clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= '1;
            sck_q <= '0;
            si_q  <= '0;
            sck_d <= 1'b0;
        end else begin
            cs_q  <= {cs_q[STAGES-2:0], cs_n};
            sck_q <= {sck_q[STAGES-2:0], sck};
            si_q  <= {si_q[STAGES-2:0], si};
            sck_d <= sck_q[STAGES-1];
        end
    end

    // Decode selection and clock edges from the synchronized levels.
    always_comb begin
        sel      = ~cs_q[STAGES-1];
        sck_rise = sck_q[STAGES-1] & ~sck_d;
        sck_fall = ~sck_q[STAGES-1] & sck_d;
        si_s     = si_q[STAGES-1];
    end

endmodule

// File: rtl/fr_cmd_decoder.sv
// Tracks the transaction phase from synchronized rising clock edges. It checks
// the opcode and busy flag, collects the address, and counts dummy clocks.
// Raises load for one cycle when data output may begin. Assumes sel low
// clears the transaction.
module fr_cmd_decoder #(
    parameter int AW      = 8,
    parameter int DUMMY_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                sck_rise,
    input  logic                si_s,
    input  logic                busy,
    input  logic [DUMMY_W-1:0]  dummy_cfg,
    output fr_pkg::fr_phase_e   phase,
    output logic                load,
    output logic [AW-1:0]       load_addr
);
    import fr_pkg::*;

    localparam int CNT_W = $clog2(FR_BUS_ABITS);
    localparam logic [CNT_W-1:0]   OPC_LAST  = CNT_W'(FR_OPC_BITS - 1);
    localparam logic [CNT_W-1:0]   ADDR_LAST = CNT_W'(FR_BUS_ABITS - 1);
    localparam logic [CNT_W-1:0]   CNT_ONE   = CNT_W'(1);
    localparam logic [DUMMY_W-1:0] D_ONE     = DUMMY_W'(1);

    logic [CNT_W-1:0]   bit_cnt;
    logic [6:0]         opc_sr;
    logic [AW-1:0]      addr_sr;
    logic [DUMMY_W-1:0] dcnt;

    // Advance the phase state machine on each rising serial-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_OPC;
            bit_cnt   <= '0;
            opc_sr    <= '0;
            addr_sr   <= '0;
            dcnt      <= '0;
            load      <= 1'b0;
            load_addr <= '0;
        end else begin
            load <= 1'b0;
            if (!sel) begin
                phase   <= PH_OPC;
                bit_cnt <= '0;
            end else if (sck_rise) begin
                case (phase)
                    PH_OPC: begin
                        opc_sr  <= {opc_sr[5:0], si_s};
                        bit_cnt <= bit_cnt + CNT_ONE;
                        if (bit_cnt == OPC_LAST) begin
                            bit_cnt <= '0;
                            if (({opc_sr, si_s} == FR_OPCODE) && !busy)
                                phase <= PH_ADDR;
                            else
                                phase <= PH_IGNORE;
                        end
                    end
                    PH_ADDR: begin
                        addr_sr <= {addr_sr[AW-2:0], si_s};
                        bit_cnt <= bit_cnt + CNT_ONE;
                        if (bit_cnt == ADDR_LAST) begin
                            bit_cnt   <= '0;
                            load_addr <= {addr_sr[AW-2:0], si_s};
                            if (dummy_cfg == '0) begin
                                phase <= PH_DATA;
                                load  <= 1'b1;
                            end else begin
                                dcnt  <= dummy_cfg;
                                phase <= PH_DUMMY;
                            end
                        end
                    end
                    PH_DUMMY: begin
                        dcnt <= dcnt - D_ONE;
                        if (dcnt == D_ONE) begin
                            phase <= PH_DATA;
                            load  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/fr_data_shifter.sv
// Holds the read-only array and shifts bytes out MSB first, one bit per
// falling serial-clock edge during the data phase. The read address wraps
// naturally at 2**AW. Assumes load never coincides with a falling edge.
module fr_data_shifter #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          in_data,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          sck_fall,
    output logic          so,
    output logic          so_oe
);
    import fr_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [2:0]    LAST_BIT = 3'd7;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_addr;
    logic [6:0]    sh;
    logic [2:0]    bits_left;

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign mem[g] = fr_rom_byte(g);
    end

    // Load the start address, then shift data bits on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so        <= 1'b0;
            so_oe     <= 1'b0;
            rd_addr   <= '0;
            sh        <= '0;
            bits_left <= '0;
        end else if (!sel) begin
            so_oe     <= 1'b0;
            bits_left <= '0;
        end else if (load) begin
            rd_addr   <= load_addr;
            bits_left <= '0;
        end else if (in_data && sck_fall) begin
            so_oe <= 1'b1;
            if (bits_left == '0) begin
                {so, sh}  <= mem[rd_addr];
                bits_left <= LAST_BIT;
                rd_addr   <= rd_addr + A_ONE;
            end else begin
                so        <= sh[6];
                sh        <= {sh[5:0], 1'b0};
                bits_left <= bits_left - 3'd1;
            end
        end
    end

endmodule

// File: rtl/fr_responder.sv
// Top of the fast-read responder: pin synchronizer, phase decoder and data
// shifter. Drives so with an output enable for an external tri-state pad.
module fr_responder #(
    parameter int ADDR_BITS   = 8,
    parameter int DUMMY_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               si,
    input  logic               busy,
    input  logic [DUMMY_W-1:0] dummy_cfg,
    output logic               so,
    output logic               so_oe
);
    import fr_pkg::*;

    logic          sel;
    logic          sck_rise;
    logic          sck_fall;
    logic          si_s;
    fr_phase_e     phase;
    logic          load;
    logic [ADDR_BITS-1:0] load_addr;
    logic          in_data;

    assign in_data = (phase == PH_DATA);

    fr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .sel      (sel),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s)
    );

    fr_cmd_decoder #(.AW(ADDR_BITS), .DUMMY_W(DUMMY_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sck_rise  (sck_rise),
        .si_s      (si_s),
        .busy      (busy),
        .dummy_cfg (dummy_cfg),
        .phase     (phase),
        .load      (load),
        .load_addr (load_addr)
    );

    fr_data_shifter #(.AW(ADDR_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .in_data   (in_data),
        .load      (load),
        .load_addr (load_addr),
        .sck_fall  (sck_fall),
        .so        (so),
        .so_oe     (so_oe)
    );

endmodule

// File: rtl/fr_responder_chk.sv
// Property checker for the fast-read responder, bound to the top module.
module fr_responder_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              sck_fall,
    input fr_pkg::fr_phase_e phase,
    input logic              so,
    input logic              so_oe
);
    import fr_pkg::*;

    // R6: the pin is driven only in the data phase
    p_oe_data_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (phase == PH_DATA));

    // R8: deselect returns to opcode decode with the pin released
    p_deselect_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (phase == PH_OPC && !so_oe));

    // R4: data bit moves only after a falling edge
    p_so_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so));

    // R4: driving begins on a falling edge
    p_drive_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(sck_fall));

    // R1: an ignored command never drives the pin
    p_ignored_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |-> !so_oe);

endmodule

bind fr_responder fr_responder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .sck_fall (sck_fall),
    .phase    (phase),
    .so       (so),
    .so_oe    (so_oe)
);

// File: tb/fr_responder_bench.sv
module fr_responder_bench;

    localparam int H = 8;   // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       busy = 1'b0;
    logic [3:0] dummy_cfg = 4'd8;
    logic       so;
    logic       so_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fr_responder u_fr_responder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .busy(busy), .dummy_cfg(dummy_cfg), .so(so), .so_oe(so_oe)
    );

    function automatic int exp_byte(input int a);
        int lo;
        lo = a & 255;
        return ((lo * 37 + 11) & 255) ^ (lo >> 2);
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bmode: 0 idle, 1 whole transaction, 2 only the clock of opcode bit 8, 3 from address on
    task automatic do_read(input bit m3, input int bmode, input logic [7:0] opc,
                           input logic [23:0] adr, input int dummy, input int nbytes,
                           input bit want, input string req);
        int pre_drv;
        int quiet_drv;
        int gbyte;
        int omiss;
        int total;
        pre_drv = 0; quiet_drv = 0; gbyte = 0; omiss = 0;
        total = 32 + dummy + nbytes * 8;
        dummy_cfg = 4'(dummy);
        sck = m3;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(4);
        for (int k = 0; k < total; k++) begin
            sck = 1'b0;
            case (bmode)
                1: busy = 1'b1;
                2: busy = (k == 7);
                3: busy = (k >= 8);
                default: busy = 1'b0;
            endcase
            si = (k < 8) ? opc[7-k] : (k < 32) ? adr[31-k] : 1'b0;
            wait_clk(H);
            if (k < 32 + dummy) begin
                if (so_oe) pre_drv++;
            end else if (!want) begin
                if (so_oe) quiet_drv++;
            end else begin
                int j;
                j = k - 32 - dummy;
                if (!so_oe) omiss++;
                gbyte = (gbyte << 1) | int'(so);
                if (j % 8 == 7) begin
                    int e;
                    e = exp_byte(int'(adr[7:0]) + j / 8);
                    check((gbyte & 255) == e && omiss == 0, req,
                          (gbyte & 255) | (omiss << 8), e);
                    gbyte = 0; omiss = 0;
                end
            end
            sck = 1'b1;
            wait_clk(H);
            if (!m3) sck = 1'b0;
        end
        check(pre_drv == 0, "R6 quiet before data", pre_drv, 0);
        if (!want) check(quiet_drv == 0, req, quiet_drv, 0);
        cs_n = 1'b1;
        busy = 1'b0;
        wait_clk(5);
        check(so_oe == 1'b0, "R6 release after cs_n", int'(so_oe), 0);
        wait_clk(4);
    endtask

    // Sends only the first nbits of a valid command, then deselects.
    task automatic do_abort(input bit m3, input int nbits);
        logic [31:0] frame;
        frame = {8'h0B, 24'h000040};
        sck = m3;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(4);
        for (int k = 0; k < nbits; k++) begin
            sck = 1'b0;
            si = frame[31-k];
            wait_clk(H);
            sck = 1'b1;
            wait_clk(H);
            if (!m3) sck = 1'b0;
        end
        cs_n = 1'b1;
        wait_clk(6);
        check(so_oe == 1'b0, "R8 abort leaves pin released", int'(so_oe), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R11: reset state
        check(so_oe == 1'b0 && so == 1'b0, "R11 reset outputs",
              {so_oe, so}, 0);

        // R3, R9, R10: dummy gap sweep in both clock modes
        for (int d = 0; d < 10; d++) begin
            for (int m = 0; m < 2; m++) begin
                do_read(m[0], 0, 8'h0B, 24'(d * 23 + m * 101), d, 2, 1'b1,
                        m ? "R3/R9 mode3 data" : "R3/R4 mode0 data");
            end
        end

        // R5: wrap from top of array to zero
        do_read(1'b0, 0, 8'h0B, 24'h0000FD, 8, 5, 1'b1, "R5 wrap");
        // R5: run through the whole array and past it in one burst
        do_read(1'b1, 0, 8'h0B, 24'h000080, 8, 260, 1'b1, "R5 long burst");

        // R2: upper address bits ignored
        do_read(1'b0, 0, 8'h0B, 24'hA5C310, 4, 2, 1'b1, "R2 high bits");
        do_read(1'b1, 0, 8'h0B, 24'hFFFF10, 4, 2, 1'b1, "R2 high bits set");

        // R1: wrong opcodes produce no drive
        do_read(1'b0, 0, 8'h03, 24'h000010, 8, 2, 1'b0, "R1 opcode 03");
        do_read(1'b0, 0, 8'h0A, 24'h000010, 8, 2, 1'b0, "R1 opcode 0A");
        do_read(1'b1, 0, 8'h8B, 24'h000010, 8, 2, 1'b0, "R1 opcode 8B");

        // R7: busy handling
        do_read(1'b0, 1, 8'h0B, 24'h000022, 8, 2, 1'b0, "R7 busy throughout");
        do_read(1'b1, 2, 8'h0B, 24'h000022, 8, 2, 1'b0, "R7 busy at opcode end");
        do_read(1'b0, 3, 8'h0B, 24'h000022, 8, 2, 1'b1, "R7 busy after opcode");

        // R8: abort mid-address and mid-opcode, then normal reads
        do_abort(1'b0, 13);
        do_read(1'b0, 0, 8'h0B, 24'h000077, 2, 2, 1'b1, "R8 read after abort");
        do_abort(1'b1, 5);
        do_read(1'b1, 0, 8'h0B, 24'h0000E1, 0, 2, 1'b1, "R8 read after abort mode3");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule